// File: doc/BRIEF.md
# CPU Differential Clock Stop Controller

This block decides, cycle by cycle, what each of three differential CPU clock pairs does: toggle normally, park with the true leg held high, or float both legs. It runs on the CPU clock. Two stop sources feed it. The first is an asynchronous active-low power-down input. The second is an asynchronous active-low CPU-stop input. Static configuration bits complete the decision: one stoppable bit and one enable bit per pair, and one park-mode bit for each stop source.

For every pair the block produces a clock-gate enable and a 2-bit drive-state code for the analog output stage. Drive-state encoding:

| Code | Name | Meaning |
|------|------|---------|
| `00` | RUN | clock toggles |
| `01` | HIGH_6X | true leg held high at the normal drive |
| `10` | HIGH_2X | true leg held high at reduced drive |
| `11` | HIZ | both legs undriven |

Pair i uses bits `[2i+1:2i]` of `driveCode` and bit i of `gateEn`.

Both the gate and the code are registered on the rising edge. They change only while the gated output is high or parked, so the output stage never sees a runt pulse.

When a stop is released, a pair does not resume at once. It first passes through a wake phase in which the true leg is driven high. Only after that phase does the clock return.

Top module: `cpu_clk_stop`

## Requirements
- R1: After reset every pair has `gateEn`=1 and drive code RUN (`00`). `gateEn` is 1 exactly when the pair's code is RUN.
- R2: Power-down takes effect only after `pwrDownN` has been sampled low on two consecutive rising edges. The outputs change on the third edge. A low lasting a single sample has no effect.
- R3: While power-down is in effect, an enabled pair shows HIGH_2X (`10`) when `pdParkFloat`=0, and HIZ (`11`) when `pdParkFloat`=1, with `gateEn`=0.
- R4: `cpuStopN` passes through a two-flop synchroniser. A pair whose `stoppable` bit is 1 parks on the third rising edge after the input is first sampled low.
- R5: While stopped by CPU-stop, a pair shows HIGH_6X (`01`) when `stopParkFloat`=0, and HIZ (`11`) when `stopParkFloat`=1. A change of the park bit shows on the next edge.
- R6: A pair whose `stoppable` bit is 0 keeps running while `cpuStopN` is low, but still parks on power-down.
- R7: When both sources are asserted, the power-down park code applies.
- R8: After the last active stop source is released, a parked pair spends `RESTART_CYC` cycles (default 2) with `gateEn`=0 and code HIGH_6X, then returns to RUN. The restart begins on the second edge after power-down is seen high, or on the third edge after CPU-stop is seen high. A stop that is reasserted during this phase parks the pair again.
- R9: A pair whose `pairEn` bit is 0 shows HIZ with `gateEn`=0 from the next edge, whatever the stop inputs are doing. Setting the bit back to 1 restores the pair's current stop state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | asynchronous active-low reset |
| pwrDownN | input | 1 | asynchronous active-low power-down request |
| cpuStopN | input | 1 | asynchronous active-low CPU-stop request |
| stoppable | input | 3 | per pair: 1 = obeys CPU-stop, 0 = free-running |
| pairEn | input | 3 | per pair output enable |
| pdParkFloat | input | 1 | power-down park mode: 0 = high at 2x, 1 = float |
| stopParkFloat | input | 1 | CPU-stop park mode: 0 = high at 6x, 1 = float |
| gateEn | output | 3 | per pair clock gate enable |
| driveCode | output | 6 | per pair drive-state code, 2 bits each |

## Verification
A wrong synchroniser stage shows up as a park that comes one edge early or late relative to the input fall. A stuck per-pair state shows up as a pair that fails to leave HIZ or HIGH_6X on release, or that skips the wake phase, within a few cycles of the stop being lifted. Because the code is recomputed every cycle from the held state, a wrong choice of stop cause shows up as a wrong park code on the first parked cycle: for example HIGH_6X where HIGH_2X belongs when both sources are active. Random toggling of the inputs and of the configuration is compared against a cycle-level reference on every cycle, so any divergence appears on the edge where it first arises.

// File: rtl/cpu_clk_stop_pkg.sv
package cpu_clk_stop_pkg;

  typedef enum logic [1:0] {
    DRV_RUN   = 2'b00,
    DRV_HIGH6 = 2'b01,
    DRV_HIGH2 = 2'b10,
    DRV_HIZ   = 2'b11
  } drive_e;

  typedef enum logic [1:0] {
    PS_RUN  = 2'b00,
    PS_PARK = 2'b01,
    PS_WAKE = 2'b10
  } pairState_e;

  // strobe from control to datapath, one per pair
  typedef struct packed {
    logic   gate;
    drive_e code;
  } pairCmd_t;

endpackage

// File: rtl/cpu_clk_stop_sync.sv
module cpu_clk_stop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asyncIn,
  output logic [STAGES-1:0] stage
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else if (s == 0) stage[s] <= asyncIn;
      else stage[s] <= stage[(s > 0) ? s - 1 : 0];
    end
  end

endmodule

// File: rtl/cpu_clk_stop_ctrl.sv
module cpu_clk_stop_ctrl
  import cpu_clk_stop_pkg::*;
#(
  parameter int NPAIR       = 3,
  parameter int RESTART_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDownN,
  input  logic                 cpuStopN,
  input  logic [NPAIR-1:0]     stoppable,
  input  logic [NPAIR-1:0]     pairEn,
  input  logic                 pdParkFloat,
  input  logic                 stopParkFloat,
  output pairCmd_t [NPAIR-1:0] cmd,
  output logic                 pdActive
);

  localparam int CNT_W = (RESTART_CYC > 1) ? $clog2(RESTART_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESTART_CYC - 1);

  logic [1:0] pdStage;
  logic [1:0] stopStage;
  logic       stopReq;

  cpu_clk_stop_sync #(.STAGES(2), .RST_VAL(1'b1)) pdSync (
    .clk(clk), .rstN(rstN), .asyncIn(pwrDownN), .stage(pdStage));

  cpu_clk_stop_sync #(.STAGES(2), .RST_VAL(1'b1)) stopSync (
    .clk(clk), .rstN(rstN), .asyncIn(cpuStopN), .stage(stopStage));

  // power-down counts once seen low on two consecutive edges
  assign pdActive = ~pdStage[0] & ~pdStage[1];
  assign stopReq  = ~stopStage[1];

  // R2
  pd_two_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdActive |-> (!$past(pwrDownN) && !$past(pwrDownN, 2)));

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    pairState_e       st, stNext;
    logic [CNT_W-1:0] cnt, cntNext;
    logic             stopHit;

    assign stopHit = stopReq & stoppable[i];

    always_comb begin
      stNext  = st;
      cntNext = cnt;
      unique case (st)
        PS_RUN: if (pdActive || stopHit) stNext = PS_PARK;
        PS_PARK: begin
          if (!pdActive && !stopHit) begin
            stNext  = PS_WAKE;
            cntNext = CNT_LOAD;
          end
        end
        PS_WAKE: begin
          if (pdActive || stopHit) stNext = PS_PARK;
          else if (cnt == '0)      stNext = PS_RUN;
          else                     cntNext = cnt - 1'b1;
        end
        default: stNext = PS_RUN;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st  <= PS_RUN;
        cnt <= '0;
      end else begin
        st  <= stNext;
        cnt <= cntNext;
      end
    end

    always_comb begin
      if (!pairEn[i]) begin
        cmd[i] = '{gate: 1'b0, code: DRV_HIZ};
      end else begin
        unique case (stNext)
          PS_RUN:  cmd[i] = '{gate: 1'b1, code: DRV_RUN};
          PS_WAKE: cmd[i] = '{gate: 1'b0, code: DRV_HIGH6};
          default: begin
            if (pdActive)
              cmd[i] = '{gate: 1'b0, code: pdParkFloat ? DRV_HIZ : DRV_HIGH2};
            else
              cmd[i] = '{gate: 1'b0, code: stopParkFloat ? DRV_HIZ : DRV_HIGH6};
          end
        endcase
      end
    end

    // R6
    free_run_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!stoppable[i] && !pdActive && st != PS_PARK) |=> st != PS_PARK);
  end

endmodule

// File: rtl/cpu_clk_stop_dp.sv
module cpu_clk_stop_dp
  import cpu_clk_stop_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pairCmd_t [NPAIR-1:0] cmd,
  output logic [NPAIR-1:0]     gateEn,
  output logic [2*NPAIR-1:0]   driveCode
);

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic   gateR;
    drive_e codeR;

    // both registered on the rising edge: gate output is high there
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gateR <= 1'b1;
        codeR <= DRV_RUN;
      end else begin
        gateR <= cmd[i].gate;
        codeR <= cmd[i].code;
      end
    end

    assign gateEn[i]          = gateR;
    assign driveCode[2*i +: 2] = codeR;

    // R1
    gate_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      gateR == (codeR == DRV_RUN));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateR) |-> ($past(codeR) == DRV_HIGH6 || $past(codeR) == DRV_HIZ));
  end

endmodule

// File: rtl/cpu_clk_stop.sv
module cpu_clk_stop
  import cpu_clk_stop_pkg::*;
#(
  parameter int NPAIR       = 3,
  parameter int RESTART_CYC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrDownN,
  input  logic               cpuStopN,
  input  logic [NPAIR-1:0]   stoppable,
  input  logic [NPAIR-1:0]   pairEn,
  input  logic               pdParkFloat,
  input  logic               stopParkFloat,
  output logic [NPAIR-1:0]   gateEn,
  output logic [2*NPAIR-1:0] driveCode
);

  pairCmd_t [NPAIR-1:0] cmd;
  logic                 pdActive;

  cpu_clk_stop_ctrl #(.NPAIR(NPAIR), .RESTART_CYC(RESTART_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .cpuStopN(cpuStopN),
    .stoppable(stoppable), .pairEn(pairEn), .pdParkFloat(pdParkFloat),
    .stopParkFloat(stopParkFloat), .cmd(cmd), .pdActive(pdActive));

  cpu_clk_stop_dp #(.NPAIR(NPAIR)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .gateEn(gateEn), .driveCode(driveCode));

  for (genvar i = 0; i < NPAIR; i++) begin : g_chk
    // R7
    pd_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pdActive && pairEn[i]) |=>
        driveCode[2*i +: 2] == ($past(pdParkFloat) ? 2'b11 : 2'b10));
  end

endmodule

// File: tb/cpu_clk_stop_test.sv
module cpu_clk_stop_test;

  localparam int RCYC = 2;

  logic       clk = 1'b0;
  logic       rstN, pwrDownN, cpuStopN, pdParkFloat, stopParkFloat;
  logic [2:0] stoppable, pairEn;
  logic [2:0] gateEn;
  logic [5:0] driveCode;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cpu_clk_stop #(.NPAIR(3), .RESTART_CYC(RCYC)) uut (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .cpuStopN(cpuStopN),
    .stoppable(stoppable), .pairEn(pairEn), .pdParkFloat(pdParkFloat),
    .stopParkFloat(stopParkFloat), .gateEn(gateEn), .driveCode(driveCode));

  task automatic chk(input string tag, input logic [2:0] g, input logic [5:0] c);
    checks++;
    if (gateEn !== g || driveCode !== c) begin
      bad++;
      $display("FAIL %s: gate=%b code=%b expected gate=%b code=%b",
               tag, gateEn, driveCode, g, c);
    end
  endtask

  // cycle-level reference built from the requirements
  logic       mp1 = 1, mp2 = 1, ms1 = 1, ms2 = 1;
  int         mst [3] = '{0, 0, 0};
  int         mcnt[3] = '{0, 0, 0};
  logic [2:0] eg = 3'b111;
  logic [5:0] ec = 6'b0;
  bit         modelOn = 0;

  always @(posedge clk) begin
    logic pd, sr, hit;
    int   ns;
    if (!rstN) begin
      mp1 = 1; mp2 = 1; ms1 = 1; ms2 = 1;
      for (int i = 0; i < 3; i++) begin mst[i] = 0; mcnt[i] = 0; end
      eg = 3'b111; ec = 6'b0;
    end else begin
      pd = !mp1 && !mp2;
      sr = !ms2;
      for (int i = 0; i < 3; i++) begin
        hit = sr && stoppable[i];
        ns = mst[i];
        case (mst[i])
          0: if (pd || hit) ns = 1;
          1: if (!pd && !hit) begin ns = 2; mcnt[i] = RCYC - 1; end
          default: begin
            if (pd || hit) ns = 1;
            else if (mcnt[i] == 0) ns = 0;
            else mcnt[i] = mcnt[i] - 1;
          end
        endcase
        mst[i] = ns;
        if (!pairEn[i]) begin eg[i] = 0; ec[2*i +: 2] = 2'b11; end
        else if (ns == 0) begin eg[i] = 1; ec[2*i +: 2] = 2'b00; end
        else if (ns == 2) begin eg[i] = 0; ec[2*i +: 2] = 2'b01; end
        else if (pd) begin eg[i] = 0; ec[2*i +: 2] = pdParkFloat ? 2'b11 : 2'b10; end
        else begin eg[i] = 0; ec[2*i +: 2] = stopParkFloat ? 2'b11 : 2'b01; end
      end
    end
    mp2 = mp1; mp1 = pwrDownN;
    ms2 = ms1; ms1 = cpuStopN;
    modelOn = 1;
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      for (int i = 0; i < 3; i++) begin
        checks++;
        if (gateEn[i] !== eg[i] || driveCode[2*i +: 2] !== ec[2*i +: 2]) begin
          bad++;
          $display("FAIL %s: pair %0d gate=%b code=%b expected gate=%b code=%b",
                   (ec[2*i +: 2] == 2'b00) ? "R1" : (ec[2*i +: 2] == 2'b01) ? "R5" :
                   (ec[2*i +: 2] == 2'b10) ? "R3" : "R9",
                   i, gateEn[i], driveCode[2*i +: 2], eg[i], ec[2*i +: 2]);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; pwrDownN = 1; cpuStopN = 1; stoppable = 3'b111; pairEn = 3'b111;
    pdParkFloat = 0; stopParkFloat = 0;
    step(3);
    rstN = 1;
    step(1);
    chk("R1 reset", 3'b111, 6'b000000);

    // R4 stop latency, R5 park float
    stopParkFloat = 1; cpuStopN = 0;
    step(1); chk("R4 edge1", 3'b111, 6'b000000);
    step(1); chk("R4 edge2", 3'b111, 6'b000000);
    step(1); chk("R4 parked", 3'b000, 6'b111111);
    stopParkFloat = 0;
    step(1); chk("R5 high6", 3'b000, 6'b010101);
    stopParkFloat = 1;
    step(1); chk("R5 float", 3'b000, 6'b111111);
    // R8 restart
    cpuStopN = 1;
    step(2); chk("R8 still parked", 3'b000, 6'b111111);
    step(1); chk("R8 wake1", 3'b000, 6'b010101);
    step(1); chk("R8 wake2", 3'b000, 6'b010101);
    step(1); chk("R8 resumed", 3'b111, 6'b000000);

    // R6 free-run pairs
    stoppable = 3'b010; cpuStopN = 0;
    step(3); chk("R6 freerun", 3'b101, 6'b001100);
    // R7 priority and R3 park modes
    pwrDownN = 0; pdParkFloat = 0;
    step(3); chk("R7 pd over stop", 3'b000, 6'b101010);
    pdParkFloat = 1;
    step(1); chk("R3 float", 3'b000, 6'b111111);
    pwrDownN = 1;
    step(2); chk("R8 pd release", 3'b000, 6'b011101);
    step(1); chk("R8 pd wake2", 3'b000, 6'b011101);
    step(1); chk("R6 after pd", 3'b101, 6'b001100);
    cpuStopN = 1;
    step(6); chk("R8 all run", 3'b111, 6'b000000);

    // R2 single-sample glitch
    pwrDownN = 0; step(1); pwrDownN = 1;
    step(1); chk("R2 glitch a", 3'b111, 6'b000000);
    step(1); chk("R2 glitch b", 3'b111, 6'b000000);
    step(2); chk("R2 glitch c", 3'b111, 6'b000000);

    // R9 disable
    pairEn = 3'b110;
    step(1); chk("R9 disabled", 3'b110, 6'b000011);
    cpuStopN = 0; stoppable = 3'b111; stopParkFloat = 0;
    step(3); chk("R9 disabled stop", 3'b000, 6'b010111);
    pairEn = 3'b111;
    step(1); chk("R9 reenable", 3'b000, 6'b010101);
    cpuStopN = 1;
    step(6);

    // random phase, checked against the reference each cycle
    for (int n = 0; n < 4000; n++) begin
      step(1);
      if ($urandom_range(15) == 0) cpuStopN = ~cpuStopN;
      if ($urandom_range(39) == 0) pwrDownN = ~pwrDownN;
      if ($urandom_range(49) == 0) stoppable = 3'($urandom);
      if ($urandom_range(59) == 0) pairEn = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b111;
      if ($urandom_range(29) == 0) pdParkFloat = ~pdParkFloat;
      if ($urandom_range(29) == 0) stopParkFloat = ~stopParkFloat;
    end
    step(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule